// File: doc/BRIEF.md
# Configurable Look-Up-Table Logic Cell

This block is one programmable cell of a logic fabric. A four-input look-up table returns one bit of a 16-bit truth-table mask, with the four data inputs forming the index. A single storage bit sits beside the table. Static configuration ports choose how that bit behaves: as a D, T, JK or SR flip-flop. It also has a clock enable, a synchronous clear and a synchronous load. Three asynchronous controls act on it: a device-wide active-low reset, a clear, and a preset/load input that either sets the bit or copies data input 2 into it.

Three outputs each pick, independently, the table result or the stored bit. The table and the register can therefore do unrelated jobs. Packed mode feeds the register from data input 3 instead of the table. Chain mode feeds it from the neighbouring cell's chain input and drives the stored bit onto a chain output, which builds shift chains that bypass the table. A feedback option puts the stored bit in place of table index bit 3, so the table can compute the cell's own next state.

Top module: `lcell_top`

## Requirements
- R1: The table output `lutOut` equals `cfgMask[idx]`. The index `idx` is `{dataIn[3], dataIn[2], dataIn[1], dataIn[0]}`, with `dataIn[3]` as the most significant bit, unless R13 applies.
- R2: While `rstDevN` is 0, the stored bit is 0, whatever every other control is doing.
- R3: While `aclr` is 1 (and `rstDevN` is 1), the stored bit is 0. Clear overrides `apreLd`.
- R4: While `apreLd` is 1 and neither R2 nor R3 applies, the stored bit is set to 1 when `cfgAload` is 0. When `cfgAload` is 1 it takes the value of `dataIn[2]`.
- R5: With `ena` at 0, a clock edge leaves the stored bit unchanged. The synchronous controls and the mode function are ignored.
- R6: With `ena` at 1 and `sclr` at 1, the stored bit becomes 0 at the clock edge, even when `sload` is also 1.
- R7: With `ena` at 1, `sclr` at 0 and `sload` at 1, the stored bit takes `dataIn[2]` at the clock edge, whatever the mode.
- R8: In D mode (`cfgMode` = 0) the stored bit loads a data source at the clock edge. The source is `chainIn` when `cfgChain` is 1; otherwise it is `dataIn[3]` when `cfgPacked` is 1; otherwise it is the table output.
- R9: In T mode (`cfgMode` = 1) the stored bit inverts at the clock edge when the table output is 1, and holds when it is 0.
- R10: In JK mode (`cfgMode` = 2), J is `dataIn[0]` and K is `dataIn[1]`. The pair {J,K} acts as follows: 00 holds, 01 clears, 10 sets, 11 toggles.
- R11: In SR mode (`cfgMode` = 3), S is `dataIn[0]` and R is `dataIn[1]`. The pair {S,R} acts as follows: 00 holds, 01 clears, 10 sets, 11 holds.
- R12: Bits 0, 1 and 2 of `cfgOutSel` steer `outLocal`, `outRow` and `outDirect`: a 1 selects the stored bit and a 0 the table output. `chainOut` always carries the stored bit.
- R13: With `cfgFeedback` at 1, the stored bit replaces `dataIn[3]` as table index bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rstDevN | input | 1 | Device-wide asynchronous reset, active low |
| cfgMask | input | 16 | Truth-table mask |
| cfgMode | input | 2 | Register behaviour: 0 D, 1 T, 2 JK, 3 SR |
| cfgAload | input | 1 | 0: `apreLd` presets; 1: `apreLd` loads `dataIn[2]` |
| cfgFeedback | input | 1 | Stored bit replaces table index bit 3 |
| cfgChain | input | 1 | D source is `chainIn` |
| cfgPacked | input | 1 | D source is `dataIn[3]` |
| cfgOutSel | input | 3 | Per-output steering, 1 = stored bit |
| dataIn | input | 4 | Table inputs |
| chainIn | input | 1 | Previous cell's chain output |
| ena | input | 1 | Clock enable |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of `dataIn[2]` |
| aclr | input | 1 | Asynchronous clear, active high |
| apreLd | input | 1 | Asynchronous preset/load, active high |
| outLocal | output | 1 | Steered output 0 |
| outRow | output | 1 | Steered output 1 |
| outDirect | output | 1 | Steered output 2 |
| chainOut | output | 1 | Stored bit to the next cell |

## Verification
The table is tried with an AND mask and a parity mask, which tells apart a correct index order from a merely non-constant output. The register is driven through every {J,K} and {S,R} pair, so the JK toggle is distinguished from the SR hold on the same inputs. Output steering is tried while the clock enable holds the stored bit against a different table value, so that steering to the wrong source shows. Priority cases stack controls (clear with load, async clear with preset, device reset with preset), and the chain, packed and feedback sources are each tried with values that differ from what the table would give.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {
    MODE_D  = 2'd0,
    MODE_T  = 2'd1,
    MODE_JK = 2'd2,
    MODE_SR = 2'd3
  } regMode_e;

  // One-hot action strobes from control to datapath
  typedef struct packed {
    logic keep;
    logic zero;
    logic one;
    logic flip;
    logic take;
    logic ldSync;
  } regAct_t;

endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic     clk,
  input  logic     rstDevN,
  input  logic     ena,
  input  logic     sclr,
  input  logic     sload,
  input  regMode_e mode,
  input  logic     lutOut,
  input  logic     jIn,
  input  logic     kIn,
  output regAct_t  act
);

  always_comb begin
    act = '0;
    if (!ena) begin
      act.keep = 1'b1;
    end else if (sclr) begin
      act.zero = 1'b1;
    end else if (sload) begin
      act.ldSync = 1'b1;
    end else begin
      unique case (mode)
        MODE_D: act.take = 1'b1;
        MODE_T: begin
          if (lutOut) act.flip = 1'b1;
          else        act.keep = 1'b1;
        end
        MODE_JK: begin
          unique case ({jIn, kIn})
            2'b00: act.keep = 1'b1;
            2'b01: act.zero = 1'b1;
            2'b10: act.one  = 1'b1;
            default: act.flip = 1'b1;
          endcase
        end
        default: begin
          unique case ({jIn, kIn})
            2'b01: act.zero = 1'b1;
            2'b10: act.one  = 1'b1;
            default: act.keep = 1'b1;
          endcase
        end
      endcase
    end
  end

  // R5..R11: exactly one action per cycle
  a_r5_single_action: assert property (@(posedge clk) disable iff (!rstDevN)
    $onehot(act));

  a_r6_clear_beats_load: assert property (@(posedge clk) disable iff (!rstDevN)
    (ena && sclr && sload) |-> act.zero);

  a_r10_jk_both_toggles: assert property (@(posedge clk) disable iff (!rstDevN)
    (ena && !sclr && !sload && mode == MODE_JK && jIn && kIn) |-> act.flip);

  a_r11_sr_both_holds: assert property (@(posedge clk) disable iff (!rstDevN)
    (ena && !sclr && !sload && mode == MODE_SR && jIn && kIn) |-> act.keep);

endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
#(
  parameter int LUT_IN   = 4,
  parameter int NUM_OUTS = 3
) (
  input  logic                  clk,
  input  logic                  rstDevN,
  input  logic                  aclr,
  input  logic                  apreLd,
  input  logic                  cfgAload,
  input  logic [(1<<LUT_IN)-1:0] cfgMask,
  input  logic                  cfgFeedback,
  input  logic                  cfgChain,
  input  logic                  cfgPacked,
  input  logic [NUM_OUTS-1:0]   cfgOutSel,
  input  logic [LUT_IN-1:0]     dataIn,
  input  logic                  chainIn,
  input  regAct_t               act,
  output logic                  lutOut,
  output logic                  regQ,
  output logic [NUM_OUTS-1:0]   outs
);

  localparam int ALD_IDX = 2;
  localparam int PKD_IDX = LUT_IN - 1;
  localparam int FB_IDX  = LUT_IN - 1;

  logic [LUT_IN-1:0] lutIdx;
  logic              srcData;
  logic              nextQ;

  always_comb begin
    lutIdx = dataIn;
    if (cfgFeedback) lutIdx[FB_IDX] = regQ;
  end

  assign lutOut  = cfgMask[lutIdx];
  assign srcData = cfgChain  ? chainIn :
                   cfgPacked ? dataIn[PKD_IDX] : lutOut;

  always_comb begin
    nextQ = regQ;
    if (act.zero)   nextQ = 1'b0;
    if (act.one)    nextQ = 1'b1;
    if (act.flip)   nextQ = ~regQ;
    if (act.take)   nextQ = srcData;
    if (act.ldSync) nextQ = dataIn[ALD_IDX];
  end

  // Async priority: device reset, then clear, then preset/load
  always_ff @(posedge clk or negedge rstDevN or posedge aclr or posedge apreLd) begin
    if (!rstDevN)     regQ <= 1'b0;
    else if (aclr)    regQ <= 1'b0;
    else if (apreLd)  regQ <= cfgAload ? dataIn[ALD_IDX] : 1'b1;
    else              regQ <= nextQ;
  end

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_steer
    assign outs[g] = cfgOutSel[g] ? regQ : lutOut;
  end

  always @(posedge clk) begin
    if (!rstDevN) a_r2_devreset_zero: assert (regQ == 1'b0);
    if (rstDevN && aclr) a_r3_aclr_zero: assert (regQ == 1'b0);
  end

  a_r5_keep_stable: assert property (@(posedge clk) disable iff (!rstDevN || aclr || apreLd)
    act.keep |=> $stable(regQ));

  a_r6_sclr_clears: assert property (@(posedge clk) disable iff (!rstDevN || aclr || apreLd)
    act.zero |=> !regQ);

  a_r7_sload_data: assert property (@(posedge clk) disable iff (!rstDevN || aclr || apreLd)
    act.ldSync |=> regQ == $past(dataIn[ALD_IDX]));

  a_r9_flip_changes: assert property (@(posedge clk) disable iff (!rstDevN || aclr || apreLd)
    act.flip |=> regQ != $past(regQ));

endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic        clk,
  input  logic        rstDevN,
  input  logic [15:0] cfgMask,
  input  logic [1:0]  cfgMode,
  input  logic        cfgAload,
  input  logic        cfgFeedback,
  input  logic        cfgChain,
  input  logic        cfgPacked,
  input  logic [2:0]  cfgOutSel,
  input  logic [3:0]  dataIn,
  input  logic        chainIn,
  input  logic        ena,
  input  logic        sclr,
  input  logic        sload,
  input  logic        aclr,
  input  logic        apreLd,
  output logic        outLocal,
  output logic        outRow,
  output logic        outDirect,
  output logic        chainOut
);

  localparam int LUT_IN   = 4;
  localparam int NUM_OUTS = 3;

  regAct_t               act;
  logic                  lutOut;
  logic                  regQ;
  logic [NUM_OUTS-1:0]   outs;

  lcell_ctrl u_ctrl (
    .clk     (clk),
    .rstDevN (rstDevN),
    .ena     (ena),
    .sclr    (sclr),
    .sload   (sload),
    .mode    (regMode_e'(cfgMode)),
    .lutOut  (lutOut),
    .jIn     (dataIn[0]),
    .kIn     (dataIn[1]),
    .act     (act)
  );

  lcell_dp #(.LUT_IN(LUT_IN), .NUM_OUTS(NUM_OUTS)) u_dp (
    .clk         (clk),
    .rstDevN     (rstDevN),
    .aclr        (aclr),
    .apreLd      (apreLd),
    .cfgAload    (cfgAload),
    .cfgMask     (cfgMask),
    .cfgFeedback (cfgFeedback),
    .cfgChain    (cfgChain),
    .cfgPacked   (cfgPacked),
    .cfgOutSel   (cfgOutSel),
    .dataIn      (dataIn),
    .chainIn     (chainIn),
    .act         (act),
    .lutOut      (lutOut),
    .regQ        (regQ),
    .outs        (outs)
  );

  assign outLocal  = outs[0];
  assign outRow    = outs[1];
  assign outDirect = outs[2];
  assign chainOut  = regQ;

endmodule

// File: tb/lcell_top_test.sv
module lcell_top_test;

  logic        clk = 1'b0;
  logic        rstDevN;
  logic [15:0] cfgMask;
  logic [1:0]  cfgMode;
  logic        cfgAload, cfgFeedback, cfgChain, cfgPacked;
  logic [2:0]  cfgOutSel;
  logic [3:0]  dataIn;
  logic        chainIn, ena, sclr, sload, aclr, apreLd;
  logic        outLocal, outRow, outDirect, chainOut;

  always #4 clk = ~clk;  // 125 MHz

  lcell_top uut (.*);

  typedef struct {
    logic       q;
    logic [2:0] outs;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    nRun = 0;
  int    nFail = 0;
  bit    done = 1'b0;
  logic  mq = 1'b0;

  function automatic logic lutModel(logic q);
    logic [3:0] idx;
    idx = dataIn;
    if (cfgFeedback) idx[3] = q;  // R13
    return cfgMask[idx];           // R1
  endfunction

  // Driver: computes expected state from the requirements and pushes it
  task automatic step(string tag);
    logic l, src;
    item_t it;
    l = lutModel(mq);
    src = cfgChain ? chainIn : (cfgPacked ? dataIn[3] : l);
    if (!rstDevN)      mq = 1'b0;
    else if (aclr)     mq = 1'b0;
    else if (apreLd)   mq = cfgAload ? dataIn[2] : 1'b1;
    else if (!ena)     mq = mq;
    else if (sclr)     mq = 1'b0;
    else if (sload)    mq = dataIn[2];
    else begin
      case (cfgMode)
        2'd0: mq = src;
        2'd1: mq = l ? ~mq : mq;
        2'd2: case ({dataIn[0], dataIn[1]})
                2'b01: mq = 1'b0;
                2'b10: mq = 1'b1;
                2'b11: mq = ~mq;
                default: mq = mq;
              endcase
        default: case ({dataIn[0], dataIn[1]})
                2'b01: mq = 1'b0;
                2'b10: mq = 1'b1;
                default: mq = mq;
              endcase
      endcase
    end
    l = lutModel(mq);
    for (int k = 0; k < 3; k++) it.outs[k] = cfgOutSel[k] ? mq : l;  // R12
    it.q = mq;
    it.tag = tag;
    expQ.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops and compares after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      item_t e;
      logic [2:0] got;
      e = expQ.pop_front();
      got = {outDirect, outRow, outLocal};
      nRun++;
      if (chainOut !== e.q || got !== e.outs) begin
        nFail++;
        $display("FAIL %s: q=%b outs=%b expected q=%b outs=%b",
                 e.tag, chainOut, got, e.q, e.outs);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstDevN = 1'b0; cfgMask = 16'h8000; cfgMode = 2'd0; cfgAload = 1'b0;
    cfgFeedback = 1'b0; cfgChain = 1'b0; cfgPacked = 1'b0; cfgOutSel = 3'b010;
    dataIn = 4'h0; chainIn = 1'b0; ena = 1'b1; sclr = 1'b0; sload = 1'b0;
    aclr = 1'b0; apreLd = 1'b0;
    step("R2 reset state");
    rstDevN = 1'b1; dataIn = 4'hF;  step("R1 R8 D from AND table high");
    dataIn = 4'h7;                  step("R1 R8 D from AND table low");
    cfgMask = 16'h6996; dataIn = 4'h1; step("R1 parity index");
    // R12: hold stored 1 while table reads 0
    cfgOutSel = 3'b101; ena = 1'b0; dataIn = 4'h3; step("R5 R12 steering under hold");
    sclr = 1'b1;                    step("R5 sclr ignored without ena");
    ena = 1'b1; sload = 1'b1; dataIn = 4'h4; step("R6 clear beats load");
    sclr = 1'b0;                    step("R7 sync load of input 2");
    sload = 1'b0; cfgMode = 2'd1; cfgMask = 16'hFFFF; step("R9 toggle to 0");
    step("R9 toggle to 1");
    cfgMask = 16'h0000;             step("R9 no toggle when table 0");
    cfgMode = 2'd2; dataIn = 4'h0;  step("R10 JK hold");
    dataIn = 4'h2;                  step("R10 JK K clears");
    dataIn = 4'h1;                  step("R10 JK J sets");
    dataIn = 4'h3;                  step("R10 JK toggle to 0");
    step("R10 JK toggle to 1");
    cfgMode = 2'd3; dataIn = 4'h2;  step("R11 SR reset");
    dataIn = 4'h1;                  step("R11 SR set");
    dataIn = 4'h3;                  step("R11 SR both holds");
    dataIn = 4'h0;                  step("R11 SR none holds");
    aclr = 1'b1;                    step("R3 async clear");
    apreLd = 1'b1;                  step("R3 clear beats preset");
    aclr = 1'b0;                    step("R4 preset");
    apreLd = 1'b0; ena = 1'b0;      step("R4 preset value retained");
    cfgAload = 1'b1; apreLd = 1'b1; dataIn = 4'h0; step("R4 async load of input 2 low");
    dataIn = 4'h4;                  step("R4 async load of input 2 high");
    rstDevN = 1'b0;                 step("R2 device reset beats preset/load");
    rstDevN = 1'b1; apreLd = 1'b0; ena = 1'b1; cfgMode = 2'd0;
    cfgChain = 1'b1; chainIn = 1'b1; dataIn = 4'h0; step("R8 chain source high");
    chainIn = 1'b0; dataIn = 4'hF; cfgMask = 16'hFFFF; step("R8 chain source low");
    cfgChain = 1'b0; cfgPacked = 1'b1; cfgMask = 16'h0000; dataIn = 4'h8;
    step("R8 packed source from input 3");
    cfgOutSel = 3'b011; step("R12 packed, table on direct");
    cfgPacked = 1'b0; cfgFeedback = 1'b1; cfgMask = 16'h00FF; dataIn = 4'h8;
    step("R13 feedback invert");
    step("R13 feedback invert again");
    step("R13 feedback third");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule